// File: doc/BRIEF.md
# Video Packet Capture Controller for a Serial Display Link

This block sits behind the deserializers of a MIPI DSI receiver. Each clock it may take one word from every data lane, eight bits per lane by default (sixteen with `GEAR = 16`), together with a valid strobe and a start-of-transmission marker. It rebuilds the packet byte stream by visiting the active lanes in turn, parses packet headers, and turns the video timing packets into level signals for vertical sync, horizontal sync and data enable. Pixel payload bytes are passed on in the cycle after they arrive, each in the byte slot where it entered, with a per-slot enable.

The block handles only non-burst video with sync pulses. A vertical-start or vertical-end packet also raises horizontal sync, so every vertical event marks a line start. Header error-correction bytes and payload checksums are consumed and discarded without checking. Each packet opens its own transmission. Anything between the last byte of a packet and the next start marker is line padding and is ignored.

All bytes in one input word are parsed in the same cycle by a chain of per-byte packet state machines. The states are Wait (idle until a start marker), Id (identifier byte), Data0 and Data1 (the two header data bytes, which form the word count for long packets), Ecc, Payload, Check0 and Check1. The transitions are: Wait to Id on a start marker; Id to Data0; Data0 to Data1; Data1 to Ecc; Ecc to Wait for a short packet; Ecc to Check0 for a long packet with word count zero; Ecc to Payload otherwise; Payload to Check0 on its last byte; Check0 to Check1; Check1 to Wait. A start marker forces Id from any state.

Top module: `dsi_video_capture`

## Requirements
- R1: Packet bytes are taken from lane 0 up to lane N-1 in turn, with N = `lanes_m1_i` + 1. In 16-bit gear, the low byte of every lane comes before the high byte of any lane. The byte in lane l, byte position b, is presented on `pix_data_o[8k+7:8k]`, where k = b*4 + l, and is enabled by `pix_be_o[k]`.
- R2: The data type is bits 5:0 of the identifier byte; bits 7:6 are ignored. A packet is long when the low nibble of its data type is 9 or more, and short (4 bytes) otherwise. A long header carries a little-endian word count and is followed by the payload and two checksum bytes.
- R3: A vertical-start packet (type 0x01) sets `vsync_o` and `hsync_o`.
- R4: A vertical-end packet (type 0x11) clears `vsync_o` and sets `hsync_o`.
- R5: A horizontal-start packet (0x21) sets `hsync_o`; a horizontal-end packet (0x31) clears it.
- R6: For the pixel types 0x3E, 0x1E and 0x2E, exactly word-count payload bytes are enabled, in arrival order. `de_o` is high exactly in the cycles where at least one byte is enabled. A word count of zero enables nothing.
- R7: The payload of any other long type is consumed without being output, and it leaves the sync flags unchanged.
- R8: Short packets of any other type leave the sync flags unchanged.
- R9: Bytes after the last byte of a packet, up to the next start marker, are ignored. So are cycles with `valid_i` low.
- R10: A start marker restarts header parsing at the first active slot of its word, abandoning any packet in progress.
- R11: `dt_o` shows the data type of the most recent header. `wc_o` shows the word count of the most recent long header.
- R12: All outputs change one clock after the word that causes them. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | The lane word is valid this cycle |
| sot_i | input | 1 | The word is the first word of a transmission |
| lanes_m1_i | input | 2 | Number of active lanes minus one |
| lane_word_i | input | LANES*GEAR | Deserialized words, lane l at bits [l*GEAR +: GEAR] |
| vsync_o | output | 1 | Vertical sync level |
| hsync_o | output | 1 | Horizontal sync level |
| de_o | output | 1 | Pixel payload present this cycle |
| pix_data_o | output | LANES*GEAR | Bytes of the previous word, by slot |
| pix_be_o | output | LANES*GEAR/8 | Enable per slot for pixel payload bytes |
| dt_o | output | 6 | Data type of the last header |
| wc_o | output | 16 | Word count of the last long header |

## Verification
The bench sweeps every active-lane count against short and long packets with word counts from zero to thirteen, so packet ends fall in every slot of a word. A design that miscounted lanes or slots would reorder payload bytes, and one that mishandled the zero-count or last-byte transitions would emit a byte too many or too few. After each packet it drives a word of padding that looks like sync headers. A design that re-entered the header state after a packet would then toggle the flags. Identifiers carrying virtual-channel bits, unknown short types and non-pixel long types confirm that flags and payload react only to the listed codes. A start marker inside a pixel header confirms that no payload escapes from an abandoned packet.

// File: rtl/dsi_cap_pkg.sv
package dsi_cap_pkg;

    typedef enum logic [2:0] {
        PS_WAIT,
        PS_ID,
        PS_D0,
        PS_D1,
        PS_ECC,
        PS_PAY,
        PS_CK0,
        PS_CK1
    } pstate_e;

    typedef struct packed {
        pstate_e     st;
        logic        lng;
        logic        pix;
        logic [15:0] cnt;
    } pctx_t;

    localparam logic [5:0] DT_VSTART  = 6'h01;
    localparam logic [5:0] DT_VEND    = 6'h11;
    localparam logic [5:0] DT_HSTART  = 6'h21;
    localparam logic [5:0] DT_HEND    = 6'h31;
    localparam logic [5:0] DT_RGB24   = 6'h3E;
    localparam logic [5:0] DT_RGB18P  = 6'h1E;
    localparam logic [5:0] DT_RGB18L  = 6'h2E;

    function automatic logic dt_is_long(input logic [5:0] dt);
        return dt[3:0] >= 4'h9;
    endfunction

    function automatic logic dt_is_pixel(input logic [5:0] dt);
        return (dt == DT_RGB24) || (dt == DT_RGB18P) || (dt == DT_RGB18L);
    endfunction

endpackage

// File: rtl/dsi_lane_unpack.sv
module dsi_lane_unpack #(
    parameter int LANES = 4,
    parameter int GEAR  = 8,
    localparam int BPL   = GEAR / 8,
    localparam int NSLOT = LANES * BPL,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   valid_i,
    input  logic [LW-1:0]          lanes_m1_i,
    input  logic [LANES*GEAR-1:0]  lane_word_i,
    output logic [NSLOT*8-1:0]     slot_byte_o,
    output logic [NSLOT-1:0]       slot_vld_o
);

    for (genvar b = 0; b < BPL; b++) begin : g_pos
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int K = b * LANES + l;
            assign slot_byte_o[K*8 +: 8] = lane_word_i[l*GEAR + b*8 +: 8];
            assign slot_vld_o[K]         = valid_i && (lanes_m1_i >= LW'(l));
        end
    end

endmodule

// File: rtl/dsi_byte_step.sv
module dsi_byte_step
    import dsi_cap_pkg::*;
(
    input  pctx_t      ctx_i,
    input  logic [7:0] byte_i,
    input  logic       vld_i,
    output pctx_t      ctx_o,
    output logic       id_ev_o,
    output logic       wc_ev_o,
    output logic       pay_ev_o
);

    always_comb begin
        ctx_o    = ctx_i;
        id_ev_o  = 1'b0;
        wc_ev_o  = 1'b0;
        pay_ev_o = 1'b0;
        if (vld_i) begin
            unique case (ctx_i.st)
                PS_WAIT: ctx_o.st = PS_WAIT;
                PS_ID: begin
                    id_ev_o   = 1'b1;
                    ctx_o.lng = dt_is_long(byte_i[5:0]);
                    ctx_o.pix = dt_is_pixel(byte_i[5:0]);
                    ctx_o.cnt = '0;
                    ctx_o.st  = PS_D0;
                end
                PS_D0: begin
                    ctx_o.cnt[7:0] = byte_i;
                    ctx_o.st       = PS_D1;
                end
                PS_D1: begin
                    ctx_o.cnt[15:8] = byte_i;
                    wc_ev_o         = ctx_i.lng;
                    ctx_o.st        = PS_ECC;
                end
                PS_ECC: begin
                    if (!ctx_i.lng)
                        ctx_o.st = PS_WAIT;
                    else if (ctx_i.cnt == 16'd0)
                        ctx_o.st = PS_CK0;
                    else
                        ctx_o.st = PS_PAY;
                end
                PS_PAY: begin
                    pay_ev_o  = ctx_i.pix;
                    ctx_o.cnt = ctx_i.cnt - 16'd1;
                    if (ctx_i.cnt == 16'd1)
                        ctx_o.st = PS_CK0;
                end
                PS_CK0: ctx_o.st = PS_CK1;
                PS_CK1: ctx_o.st = PS_WAIT;
                default: ctx_o.st = PS_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/dsi_pkt_parser.sv
module dsi_pkt_parser
    import dsi_cap_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NSLOT*8-1:0] slot_byte_i,
    input  logic [NSLOT-1:0]   slot_vld_i,
    output logic               id_ev_o,
    output logic [5:0]         id_dt_o,
    output logic [NSLOT*8-1:0] pix_data_o,
    output logic [NSLOT-1:0]   pix_be_o,
    output logic               de_o,
    output logic [5:0]         dt_o,
    output logic [15:0]        wc_o
);

    pctx_t               ctx_q;
    pctx_t               ctx_start;
    pctx_t [NSLOT:0]     chain;
    logic  [NSLOT-1:0]   id_ev;
    logic  [NSLOT-1:0]   wc_ev;
    logic  [NSLOT-1:0]   pay_ev;
    logic                wc_any;
    logic  [15:0]        wc_val;

    always_comb begin
        ctx_start = ctx_q;
        if (start_i) begin
            ctx_start     = '0;
            ctx_start.st  = PS_ID;
        end
    end

    assign chain[0] = ctx_start;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        dsi_byte_step u_step (
            .ctx_i    (chain[k]),
            .byte_i   (slot_byte_i[k*8 +: 8]),
            .vld_i    (slot_vld_i[k]),
            .ctx_o    (chain[k+1]),
            .id_ev_o  (id_ev[k]),
            .wc_ev_o  (wc_ev[k]),
            .pay_ev_o (pay_ev[k])
        );
    end

    always_comb begin
        id_ev_o = 1'b0;
        id_dt_o = '0;
        wc_any  = 1'b0;
        wc_val  = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (id_ev[k]) begin
                id_ev_o = 1'b1;
                id_dt_o = slot_byte_i[k*8 +: 6];
            end
            if (wc_ev[k]) begin
                wc_any = 1'b1;
                wc_val = {slot_byte_i[k*8 +: 8], chain[k].cnt[7:0]};
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctx_q <= '0;
        else
            ctx_q <= chain[NSLOT];
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_data_o <= '0;
            pix_be_o   <= '0;
            de_o       <= 1'b0;
            dt_o       <= '0;
            wc_o       <= '0;
        end else begin
            pix_data_o <= slot_byte_i;
            pix_be_o   <= pay_ev;
            de_o       <= |pay_ev;
            if (id_ev_o)
                dt_o <= id_dt_o;
            if (wc_any)
                wc_o <= wc_val;
        end
    end

endmodule

// File: rtl/dsi_sync_flags.sv
module dsi_sync_flags
    import dsi_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       id_ev_i,
    input  logic [5:0] id_dt_i,
    output logic       vsync_o,
    output logic       hsync_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_o <= 1'b0;
            hsync_o <= 1'b0;
        end else if (id_ev_i) begin
            unique case (id_dt_i)
                DT_VSTART: begin
                    vsync_o <= 1'b1;
                    hsync_o <= 1'b1;
                end
                DT_VEND: begin
                    vsync_o <= 1'b0;
                    hsync_o <= 1'b1;
                end
                DT_HSTART: hsync_o <= 1'b1;
                DT_HEND:   hsync_o <= 1'b0;
                default: begin
                    vsync_o <= vsync_o;
                    hsync_o <= hsync_o;
                end
            endcase
        end
    end

endmodule

// File: rtl/dsi_video_capture.sv
module dsi_video_capture #(
    parameter int LANES = 4,
    parameter int GEAR  = 8,
    localparam int NSLOT = LANES * GEAR / 8,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic                  sot_i,
    input  logic [LW-1:0]         lanes_m1_i,
    input  logic [LANES*GEAR-1:0] lane_word_i,
    output logic                  vsync_o,
    output logic                  hsync_o,
    output logic                  de_o,
    output logic [NSLOT*8-1:0]    pix_data_o,
    output logic [NSLOT-1:0]      pix_be_o,
    output logic [5:0]            dt_o,
    output logic [15:0]           wc_o
);

    logic [NSLOT*8-1:0] slot_byte;
    logic [NSLOT-1:0]   slot_vld;
    logic               id_ev;
    logic [5:0]         id_dt;

    dsi_lane_unpack #(.LANES(LANES), .GEAR(GEAR)) u_unpack (
        .valid_i     (valid_i),
        .lanes_m1_i  (lanes_m1_i),
        .lane_word_i (lane_word_i),
        .slot_byte_o (slot_byte),
        .slot_vld_o  (slot_vld)
    );

    dsi_pkt_parser #(.NSLOT(NSLOT)) u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (valid_i && sot_i),
        .slot_byte_i (slot_byte),
        .slot_vld_i  (slot_vld),
        .id_ev_o     (id_ev),
        .id_dt_o     (id_dt),
        .pix_data_o  (pix_data_o),
        .pix_be_o    (pix_be_o),
        .de_o        (de_o),
        .dt_o        (dt_o),
        .wc_o        (wc_o)
    );

    dsi_sync_flags u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .id_ev_i (id_ev),
        .id_dt_i (id_dt),
        .vsync_o (vsync_o),
        .hsync_o (hsync_o)
    );

endmodule

// File: rtl/dsi_cap_checker.sv
module dsi_cap_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_i,
    input logic       vsync_o,
    input logic       hsync_o,
    input logic       de_o,
    input logic [5:0] dt_o
);

    a_r3_vsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> dt_o == 6'h01);

    a_r4_vsync_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_o) |-> dt_o == 6'h11);

    a_r5_hsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) |-> (dt_o == 6'h01 || dt_o == 6'h11 || dt_o == 6'h21));

    a_r5_hsync_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_o) |-> dt_o == 6'h31);

    a_r6_de_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (dt_o == 6'h3E || dt_o == 6'h1E || dt_o == 6'h2E));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!de_o && $stable(vsync_o) && $stable(hsync_o) && $stable(dt_o)));

endmodule

bind dsi_video_capture dsi_cap_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .vsync_o (vsync_o),
    .hsync_o (hsync_o),
    .de_o    (de_o),
    .dt_o    (dt_o)
);

// File: tb/sim_dsi_video_capture.sv
module sim_dsi_video_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        sot_i = 1'b0;
    logic [1:0]  lanes_m1_i = 2'd0;
    logic [31:0] lane_word_i = '0;
    logic        vsync_o, hsync_o, de_o;
    logic [31:0] pix_data_o;
    logic [3:0]  pix_be_o;
    logic [5:0]  dt_o;
    logic [15:0] wc_o;

    always #10 clk = ~clk;

    dsi_video_capture u0 (
        .clk (clk), .rst_n (rst_n), .valid_i (valid_i), .sot_i (sot_i),
        .lanes_m1_i (lanes_m1_i), .lane_word_i (lane_word_i),
        .vsync_o (vsync_o), .hsync_o (hsync_o), .de_o (de_o),
        .pix_data_o (pix_data_o), .pix_be_o (pix_be_o),
        .dt_o (dt_o), .wc_o (wc_o)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] pkt [0:63];
    int   plen;
    int   rcv_n;
    int   pay_err;
    int   de_err;
    bit   exp_vs = 1'b0;
    bit   exp_hs = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit tb_long(input logic [5:0] dt);
        return dt[3:0] >= 4'h9;
    endfunction

    function automatic bit tb_pix(input logic [5:0] dt);
        return dt == 6'h3E || dt == 6'h1E || dt == 6'h2E;
    endfunction

    // take the outputs produced by the word driven at the previous negedge
    task automatic sample();
        de_err += (de_o != (pix_be_o != 4'd0)) ? 1 : 0;
        for (int k = 0; k < 4; k++) begin
            if (pix_be_o[k]) begin
                if (rcv_n + 4 >= 64 || pix_data_o[k*8 +: 8] != pkt[4 + rcv_n])
                    pay_err++;
                rcv_n++;
            end
        end
    endtask

    task automatic drive_word(input bit v, input bit s, input logic [31:0] w);
        @(negedge clk);
        sample();
        valid_i     = v;
        sot_i       = s;
        lane_word_i = w;
    endtask

    task automatic build(input logic [7:0] id, input int wc);
        pkt[0] = id;
        if (tb_long(id[5:0])) begin
            pkt[1] = wc[7:0];
            pkt[2] = wc[15:8];
            pkt[3] = 8'h3C;
            for (int i = 0; i < wc; i++)
                pkt[4 + i] = 8'((i * 37) + wc + 5);
            pkt[4 + wc] = 8'hC3;
            pkt[5 + wc] = 8'h99;
            plen = wc + 6;
        end else begin
            pkt[1] = 8'h5A;
            pkt[2] = 8'hA5;
            pkt[3] = 8'h3C;
            plen = 4;
        end
    endtask

    task automatic run_pkt(input logic [7:0] id, input int wc, input int n);
        logic [5:0] dt;
        int exp_cnt;
        dt = id[5:0];
        build(id, wc);
        rcv_n = 0; pay_err = 0; de_err = 0;
        exp_cnt = tb_pix(dt) ? wc : 0;
        case (dt)
            6'h01: begin exp_vs = 1'b1; exp_hs = 1'b1; end
            6'h11: begin exp_vs = 1'b0; exp_hs = 1'b1; end
            6'h21: exp_hs = 1'b1;
            6'h31: exp_hs = 1'b0;
            default: ;
        endcase
        lanes_m1_i = 2'(n - 1);
        for (int base = 0; base < plen; base += n) begin
            logic [31:0] w;
            w = 32'hFFFF_FFFF;
            for (int l = 0; l < n; l++)
                w[l*8 +: 8] = (base + l < plen) ? pkt[base + l] : 8'h21;
            drive_word(1'b1, base == 0, w);
        end
        // R9: padding that looks like sync headers, without a start marker
        drive_word(1'b1, 1'b0, 32'h0111_3101);
        drive_word(1'b0, 1'b0, 32'h0);
        drive_word(1'b0, 1'b0, 32'h0);
        chk(rcv_n == exp_cnt, "R6", "payload byte count", rcv_n, exp_cnt);
        chk(pay_err == 0, "R1", "payload byte order", pay_err, 0);
        chk(de_err == 0, "R6", "de versus byte enables", de_err, 0);
        chk(vsync_o == exp_vs, "R3", "vsync level", vsync_o, exp_vs);
        chk(hsync_o == exp_hs, "R5", "hsync level", hsync_o, exp_hs);
        chk(dt_o == dt, "R11", "data type", dt_o, dt);
        if (tb_long(dt))
            chk(wc_o == 16'(wc), "R11", "word count", wc_o, wc);
    endtask

    initial begin
        logic [7:0] ids [0:10];
        int wcs [0:7];
        ids = '{8'h81, 8'h31, 8'h08, 8'h21, 8'h3E, 8'h1E, 8'h2E, 8'h19, 8'h71, 8'h11, 8'h22};
        wcs = '{0, 1, 2, 3, 5, 7, 8, 13};
        repeat (3) @(negedge clk);
        // R12: reset values
        chk(vsync_o == 0 && hsync_o == 0 && de_o == 0, "R12", "flags in reset",
            {vsync_o, hsync_o, de_o}, 0);
        chk(pix_be_o == 0 && dt_o == 0 && wc_o == 0, "R12", "data in reset",
            pix_be_o, 0);
        rst_n = 1'b1;
        drive_word(1'b0, 1'b1, 32'h0000_0001); // R9: start marker without valid
        drive_word(1'b0, 1'b0, 32'h0);
        chk(vsync_o == 0 && dt_o == 0, "R9", "invalid word ignored", dt_o, 0);

        // sweep over lane counts, types (R2, R3, R4, R7, R8) and word counts
        for (int n = 1; n <= 4; n++) begin
            for (int t = 0; t < 11; t++) begin
                if (tb_long(ids[t][5:0])) begin
                    for (int j = 0; j < 8; j++)
                        run_pkt(ids[t], wcs[j], n);
                end else begin
                    run_pkt(ids[t], 0, n);
                end
            end
        end

        // R10: start marker abandons a pixel header in progress
        run_pkt(8'h01, 0, 4);
        rcv_n = 0; pay_err = 0; de_err = 0;
        lanes_m1_i = 2'd3;
        drive_word(1'b1, 1'b1, 32'h0000_203E);
        drive_word(1'b1, 1'b1, 32'h3C00_0011);
        drive_word(1'b1, 1'b0, 32'h0102_0304);
        drive_word(1'b0, 1'b0, 32'h0);
        drive_word(1'b0, 1'b0, 32'h0);
        chk(rcv_n == 0, "R10", "no payload from abandoned packet", rcv_n, 0);
        chk(vsync_o == 0, "R10", "restarted header decoded (R4)", vsync_o, 0);
        chk(hsync_o == 1, "R4", "hsync after vertical end", hsync_o, 1);
        chk(dt_o == 6'h11, "R10", "data type after restart", dt_o, 6'h11);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule